// File: doc/BRIEF.md
# Page Write Cache Controller

This block sits behind a serial-bus front-end and ahead of a byte-wide nonvolatile array model. The front-end first hands it a 13-bit word address. It then hands over each received data byte, and finally reports the end of the transaction. The controller gathers the bytes in a 64-byte cache built as eight lines of eight bytes. The upper seven address bits are held fixed. A 6-bit in-cache pointer picks the slot for each byte.

When the transaction ends and at least one byte was captured, a commit starts. The commit takes a fixed number of cycles. During it, every slot that was written goes to the array through a plain write strobe, address and data. `busy` stays high for the whole commit, and the front-end uses it to withhold acknowledges. A single-byte write takes the same path and commits just one byte.

Top module: `pgc_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `busy` and `mem_we` are 0.
- R2: A pulse on `addr_load` sets the cache pointer to `addr_in[5:0]` and the line-independent high part to `addr_in[12:6]`. Every array write of the following commit carries that high part in `mem_addr[12:6]`.
- R3: Each accepted `data_valid` stores `data_in` at the current pointer and then advances the pointer by one. Crossing from slot 7 of a line to slot 0 of the next line is seamless: bytes loaded at pointer 6 go to slots 6, 7, 8 and 9.
- R4: Past slot 63 the pointer wraps to slot 0. A later byte overwrites the earlier one, and only the last value written to a slot is committed.
- R5: No array write happens before the end-of-transaction pulse. `mem_we` is only ever high while `busy` is high.
- R6: A `stop_evt` pulse with at least one byte captured raises `busy` on the next cycle. `busy` then stays high for exactly COMMIT_CYCLES cycles (default 64).
- R7: During the commit, slot k is written in commit cycle k (counting from 0) if and only if it was captured. The address is `{high part, k}` and the data is its captured byte, so writes come in ascending slot order.
- R8: While `busy` is high, `addr_load`, `data_valid` and `stop_evt` are ignored. Nothing sent then is ever written, and a later stop without new data starts no commit.
- R9: The record of captured slots clears when the commit ends. A following transaction commits only the slots it wrote itself.
- R10: A `stop_evt` with no data byte since the last commit (address only) starts no commit, and `busy` stays 0.
- R11: A transaction with one data byte produces exactly one array write, at the loaded address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | One-cycle pulse: take `addr_in` as the word address |
| addr_in | input | 13 | Word address from the front-end |
| data_valid | input | 1 | One-cycle pulse: `data_in` is a received data byte |
| data_in | input | 8 | Received data byte |
| stop_evt | input | 1 | One-cycle pulse: the transaction has ended |
| busy | output | 1 | High during the commit; the front-end must not acknowledge |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The assertions assume the front-end never raises `data_valid` in the same cycle as `stop_evt` or `addr_load`. They also assume every strobe is a single-cycle pulse. The stimulus keeps to this by issuing each event on its own cycle, with idle cycles in between. It deliberately drives all three strobes while `busy` is high, because the block must ignore them. The commit-ordering check expects one commit to cover at most the 64 slots, which holds whenever COMMIT_CYCLES is at least the cache size.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    localparam int ADDR_W      = 13;
    localparam int DATA_W      = 8;
    localparam int LINE_BYTES  = 8;
    localparam int LINES       = 8;
    localparam int CACHE_BYTES = LINE_BYTES * LINES;
    localparam int PTR_W       = $clog2(CACHE_BYTES);
    localparam int HI_W        = ADDR_W - PTR_W;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // one capture request into the cache
    typedef struct packed {
        logic  en;
        ptr_t  idx;
        byte_t data;
    } cap_t;

    // one array write beat produced by the commit
    typedef struct packed {
        logic  we;
        hi_t   hi;
        ptr_t  idx;
        byte_t data;
    } beat_t;

    // pointer advance; natural wrap at the cache size
    function automatic ptr_t ptr_advance(input ptr_t p);
        return p + ptr_t'(1);
    endfunction

    function automatic addr_t join_addr(input hi_t hi, input ptr_t idx);
        return {hi, idx};
    endfunction

endpackage

// File: rtl/pgc_addr_ptr.sv
module pgc_addr_ptr
    import pgc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t load_addr,
    input  logic  step,
    output hi_t   hi,
    output ptr_t  ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi  <= '0;
            ptr <= '0;
        end else if (load) begin
            hi  <= load_addr[ADDR_W-1:PTR_W];
            ptr <= load_addr[PTR_W-1:0];
        end else if (step) begin
            ptr <= ptr_advance(ptr);
        end
    end

endmodule

// File: rtl/pgc_cache_store.sv
module pgc_cache_store
    import pgc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  cap_t                   cap,
    input  logic                   clear,
    input  ptr_t                   rd_idx,
    output byte_t                  rd_data,
    output logic [CACHE_BYTES-1:0] valid_mask,
    output logic                   any_valid
);

    logic [CACHE_BYTES-1:0][DATA_W-1:0] data_all;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        for (genvar b = 0; b < LINE_BYTES; b++) begin : g_slot
            localparam int IDX = g * LINE_BYTES + b;
            logic  v_q;
            byte_t d_q;
            logic  hit;

            assign hit = cap.en && (cap.idx == ptr_t'(IDX));

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                end else if (hit) begin
                    v_q <= 1'b1;
                    d_q <= cap.data;
                end else if (clear) begin
                    v_q <= 1'b0;
                end
            end

            assign valid_mask[IDX] = v_q;
            assign data_all[IDX]   = d_q;
        end
    end

    assign rd_data   = data_all[rd_idx];
    assign any_valid = |valid_mask;

endmodule

// File: rtl/pgc_commit_seq.sv
module pgc_commit_seq #(
    parameter int COMMIT_CYCLES = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    output logic                              busy,
    output logic [$clog2(COMMIT_CYCLES)-1:0]  cnt,
    output logic                              last
);

    localparam int CNT_W = $clog2(COMMIT_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COMMIT_CYCLES - 1);

    assign last = busy && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CNT_LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

endmodule

// File: rtl/pgc_top.sv
module pgc_top
    import pgc_pkg::*;
#(
    parameter int COMMIT_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        addr_load,
    input  logic [12:0] addr_in,
    input  logic        data_valid,
    input  logic [7:0]  data_in,
    input  logic        stop_evt,
    output logic        busy,
    output logic        mem_we,
    output logic [12:0] mem_addr,
    output logic [7:0]  mem_wdata
);

    localparam int CNT_W = $clog2(COMMIT_CYCLES);

    logic                   accept;
    hi_t                    hi;
    ptr_t                   ptr;
    cap_t                   cap;
    logic [CACHE_BYTES-1:0] valid_mask;
    logic                   any_valid;
    logic                   seq_busy;
    logic [CNT_W-1:0]       cnt;
    logic                   last;
    logic                   start;
    ptr_t                   scan_idx;
    logic                   in_range;
    byte_t                  rd_data;
    beat_t                  beat;

    // front-end events only count outside a commit
    assign accept = !seq_busy;

    assign cap.en   = data_valid && accept;
    assign cap.idx  = ptr;
    assign cap.data = data_in;

    assign start = stop_evt && accept && any_valid;

    pgc_addr_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (addr_load && accept),
        .load_addr (addr_in),
        .step      (cap.en),
        .hi        (hi),
        .ptr       (ptr)
    );

    pgc_cache_store u_store (
        .clk        (clk),
        .rst        (rst),
        .cap        (cap),
        .clear      (last),
        .rd_idx     (scan_idx),
        .rd_data    (rd_data),
        .valid_mask (valid_mask),
        .any_valid  (any_valid)
    );

    pgc_commit_seq #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (seq_busy),
        .cnt   (cnt),
        .last  (last)
    );

    // commit cycle k visits cache slot k
    assign scan_idx = ptr_t'(cnt);
    assign in_range = int'(cnt) < CACHE_BYTES;

    assign beat.we   = seq_busy && in_range && valid_mask[scan_idx];
    assign beat.hi   = hi;
    assign beat.idx  = scan_idx;
    assign beat.data = rd_data;

    assign busy      = seq_busy;
    assign mem_we    = beat.we;
    assign mem_addr  = join_addr(beat.hi, beat.idx);
    assign mem_wdata = beat.data;

endmodule

// File: rtl/pgc_chk.sv
module pgc_chk #(
    parameter int COMMIT_CYCLES = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        addr_load,
    input logic        data_valid,
    input logic        stop_evt,
    input logic        busy,
    input logic        mem_we,
    input logic [12:0] mem_addr
);

    int         run_q;
    logic       seen_q;
    logic       wrote_q;
    logic [5:0] last_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= 0;
            seen_q     <= 1'b0;
            wrote_q    <= 1'b0;
            last_idx_q <= '0;
        end else begin
            run_q <= busy ? run_q + 1 : 0;
            if (busy)
                seen_q <= 1'b0;
            else if (data_valid)
                seen_q <= 1'b1;
            if (!busy)
                wrote_q <= 1'b0;
            else if (mem_we) begin
                wrote_q    <= 1'b1;
                last_idx_q <= mem_addr[5:0];
            end
        end
    end

    // input assumption: data never shares a cycle with stop or address load
    input_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(data_valid && (stop_evt || addr_load)));

    // R5
    write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R6
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_evt));

    // R6
    commit_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_q == COMMIT_CYCLES);

    // R10
    commit_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(seen_q));

    // R2
    hi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> mem_addr[12:6] == $past(mem_addr[12:6]));

    // R7
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && wrote_q) |-> mem_addr[5:0] > last_idx_q);

endmodule

bind pgc_top pgc_chk #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_load  (addr_load),
    .data_valid (data_valid),
    .stop_evt   (stop_evt),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr)
);

// File: tb/pgc_top_tb.sv
module pgc_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int COMMIT     = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_load = 1'b0;
    logic [12:0] addr_in = '0;
    logic        data_valid = 1'b0;
    logic [7:0]  data_in = '0;
    logic        stop_evt = 1'b0;
    logic        busy;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgc_top #(.COMMIT_CYCLES(COMMIT)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .addr_load  (addr_load),
        .addr_in    (addr_in),
        .data_valid (data_valid),
        .data_in    (data_in),
        .stop_evt   (stop_evt),
        .busy       (busy),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int writes = 0;
    logic [7:0] shadow [int];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // behavioural reference
    logic [7:0] m_cache [64];
    bit         m_valid [64];
    int         m_ptr = 0;
    int         m_hi = 0;
    bit         m_busy = 0;
    int         m_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_ptr = 0; m_hi = 0;
            foreach (m_valid[i]) m_valid[i] = 0;
        end else if (m_busy) begin
            if (m_cnt == COMMIT - 1) begin
                m_busy = 0; m_cnt = 0;
                foreach (m_valid[i]) m_valid[i] = 0;
            end else m_cnt++;
        end else begin
            bit any;
            any = 0;
            if (addr_load) begin
                m_hi = int'(addr_in) / 64;
                m_ptr = int'(addr_in) % 64;
            end
            if (data_valid) begin
                m_cache[m_ptr] = data_in;
                m_valid[m_ptr] = 1;
                m_ptr = (m_ptr + 1) % 64;
            end
            foreach (m_valid[i]) if (m_valid[i]) any = 1;
            if (stop_evt && any) begin
                m_busy = 1; m_cnt = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_we;
            cycles++;
            exp_we = m_busy && m_cnt < 64 && m_valid[m_cnt % 64];
            check(busy == m_busy, "R6/R8 busy", busy, m_busy);
            check(mem_we == exp_we, "R5/R7 mem_we", mem_we, exp_we);
            if (mem_we && exp_we) begin
                check(int'(mem_addr) == m_hi * 64 + m_cnt, "R2/R3 mem_addr",
                      mem_addr, m_hi * 64 + m_cnt);
                check(mem_wdata == m_cache[m_cnt], "R4/R7 mem_wdata",
                      mem_wdata, m_cache[m_cnt]);
            end
            if (mem_we) begin
                shadow[int'(mem_addr)] = mem_wdata;
                writes++;
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input int a);
        addr_in = 13'(a); addr_load = 1'b1;
        tick(1);
        addr_load = 1'b0;
        tick(1);
    endtask

    task automatic do_byte(input int d);
        data_in = 8'(d); data_valid = 1'b1;
        tick(1);
        data_valid = 1'b0;
    endtask

    task automatic do_stop();
        stop_evt = 1'b1;
        tick(1);
        stop_evt = 1'b0;
    endtask

    // count busy cycles until the commit ends
    task automatic wait_commit(output int n);
        n = 0;
        while (busy) begin
            n++;
            tick(1);
        end
        tick(2);
    endtask

    function automatic int rd(input int a);
        if (shadow.exists(a)) return int'(shadow[a]);
        return -1;
    endfunction

    initial begin
        int n;
        int w0;
        tick(3);
        // R1
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(mem_we == 1'b0, "R1 mem_we in reset", mem_we, 0);
        rst = 1'b0;
        tick(1);
        check(busy == 1'b0 && mem_we == 1'b0, "R1 after reset", {busy, mem_we}, 0);

        // R11: single byte write
        w0 = writes;
        do_load(13'h0123);
        do_byte(8'hA5);
        tick(2);
        // R5: nothing written before the stop
        check(writes == w0, "R5 no write before stop", writes - w0, 0);
        do_stop();
        check(busy == 1'b1, "R6 busy after stop", busy, 1);
        wait_commit(n);
        check(n == COMMIT, "R6 busy length", n, COMMIT);
        check(writes - w0 == 1, "R11 one write", writes - w0, 1);
        check(rd(13'h0123) == 8'hA5, "R11 data at address", rd(13'h0123), 8'hA5);

        // R3: line crossing from slot 6
        w0 = writes;
        do_load(13'h1A06);
        for (int i = 0; i < 4; i++) do_byte(8'h10 + i);
        do_stop();
        wait_commit(n);
        check(writes - w0 == 4, "R3 write count", writes - w0, 4);
        for (int i = 0; i < 4; i++)
            check(rd(13'h1A06 + i) == 8'h10 + i, "R3 slot data", rd(13'h1A06 + i), 8'h10 + i);

        // R4: wrap past slot 63, high part 1
        w0 = writes;
        do_load(13'h007E);
        for (int i = 0; i < 66; i++) do_byte(i);
        do_stop();
        wait_commit(n);
        check(writes - w0 == 64, "R4 full cache writes", writes - w0, 64);
        check(rd(13'h007E) == 64, "R4 overwrite slot 62", rd(13'h007E), 64);
        check(rd(13'h007F) == 65, "R4 overwrite slot 63", rd(13'h007F), 65);
        check(rd(13'h0040) == 2, "R4 wrapped slot 0", rd(13'h0040), 2);
        // R2: high part held, nothing escaped the window
        check(rd(13'h0080) == -1, "R2 no write outside line window", rd(13'h0080), -1);

        // R9: mask cleared, two bytes only
        w0 = writes;
        do_load(13'h0400);
        do_byte(8'h5A);
        do_byte(8'hC3);
        do_stop();
        wait_commit(n);
        check(writes - w0 == 2, "R9 only new slots committed", writes - w0, 2);
        check(rd(13'h0401) == 8'hC3, "R9 second byte", rd(13'h0401), 8'hC3);

        // R10: address only, then stop
        w0 = writes;
        do_load(13'h0800);
        do_stop();
        tick(4);
        check(busy == 1'b0, "R10 no busy", busy, 0);
        check(writes == w0, "R10 no write", writes - w0, 0);

        // R8: stimulus during a commit is ignored
        w0 = writes;
        do_load(13'h0C10);
        do_byte(8'h77);
        do_stop();
        tick(3);
        do_load(13'h1F00);
        do_byte(8'hEE);
        tick(1);
        do_stop();
        wait_commit(n);
        check(writes - w0 == 1, "R8 only pre-commit byte", writes - w0, 1);
        check(rd(13'h1F00) == -1, "R8 busy byte not written", rd(13'h1F00), -1);
        check(rd(13'h0C11) == -1, "R8 pointer untouched", rd(13'h0C11), -1);
        do_stop();
        tick(3);
        check(busy == 1'b0, "R8 stale stop starts nothing", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule